// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control logic of a 12-bit successive-approximation converter. It makes a conversion-clock enable from the system clock through a power-of-two divider. After an optional warm-up delay it steps through a table of channel entries, either once or continuously. For each entry it drives the analog multiplexer select and a sampling strobe. It then makes twelve bit decisions from an external comparator, which compares the trial code on `dac_code` with the held input. Each finished result is written into a small result buffer.

Software controls the block through plain register-style pins. A one-cycle write strobe on `conv_wr` starts a run (data 1) or asks it to stop (data 0). Level inputs select the mode, the divider, the interrupt interval and the sequence length. A data-available flag, with an interrupt request gated by an enable, tells software that fresh results are ready. `last_addr` holds the buffer location written most recently when the flag was raised. The result write port (`wr_valid`, `wr_addr`, `wr_data`) is a stream with no back-pressure: the buffer accepts every write in the cycle it is offered. `wr_valid` is high for exactly one system clock per result.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The conversion clock ticks once every 2^`div_code` system clocks (code 0 means every clock). With `fast_start`=1, the first result write is seen 16×2^`div_code` clocks after the start strobe.
- R2: With `fast_start`=0, 20 conversion-clock ticks pass before the first conversion begins. The first write therefore comes 36×2^`div_code` clocks after the start strobe. With `fast_start`=1 there is no such delay.
- R3: Every conversion lasts 16 ticks. `sampling` is high for the first 3 of them. `mux_sel` carries the 3-bit channel of the current entry, which is field i (bits 3i+2..3i) of `chan_map` for entry i. `wr_valid` pulses during the last tick.
- R4: The twelve decisions run MSB first, one per tick, and each bit keeps the comparator value seen while that bit is on trial. Successive results go to consecutive buffer addresses that start at 0 and wrap modulo 8.
- R5: `busy` rises on a start strobe while idle. In single mode (`cont_mode`=0) it falls after the entry numbered `seq_last` has been written. In continuous mode the entry index wraps from `seq_last` back to 0 and the run goes on. A start strobe while busy is ignored.
- R6: A stop strobe (`conv_wr`=1, `conv_wdata`=0) during a run does not abort it. The conversion in progress finishes, its result is written, and `busy` then falls.
- R7: `halt`=1 ends any activity at the next clock edge: `busy` goes low, and the conversion in progress writes nothing.
- R8: `flag` is cleared by a `flag_clr` strobe and by an accepted start strobe.
- R9: `flag` is set after every N written results, where `intv_code` 0 or 1 gives N=1, codes 2..8 give N=code, 9 gives 12, and 10..15 give 16. The sample count restarts at each start. `irq` = `flag` AND `ie`.
- R10: When `flag` is set, `last_addr` takes the buffer address of the result written in that cycle.
- R11: Reading `rd_addr` returns, combinationally on `rd_data`, the last result written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Low-power/stop request; aborts at once |
| conv_wr | input | 1 | Write strobe for the convert bit |
| conv_wdata | input | 1 | Convert bit value: 1 start, 0 stop |
| cont_mode | input | 1 | 1 continuous, 0 single sequence |
| fast_start | input | 1 | 1 skips the 20-tick warm-up |
| div_code | input | 3 | Conversion clock = sysclk / 2^code |
| intv_code | input | 4 | Flag interval code |
| seq_last | input | 3 | Index of last entry in the sequence |
| chan_map | input | 24 | Channel of each entry, 3 bits per entry |
| ie | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Strobe that clears the flag |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial code |
| mux_sel | output | 3 | Analog multiplexer select |
| sampling | output | 1 | Track/hold acquisition strobe |
| dac_code | output | 12 | Trial code for the comparator |
| busy | output | 1 | Convert bit read-back |
| flag | output | 1 | Data-available flag |
| irq | output | 1 | Interrupt request |
| last_addr | output | 3 | Address latched when the flag was set |
| wr_valid | output | 1 | Result write strobe |
| wr_addr | output | 3 | Result write address |
| wr_data | output | 12 | Result value |
| rd_addr | input | 3 | Buffer read address |
| rd_data | output | 12 | Buffer read data |

## Verification
An off-by-one in the tick or frame counters moves the `sampling` edges and the `wr_valid` pulse. Because the bench keeps its own cycle-exact timeline and compares against it on every clock, such an error shows within one conversion. A wrong decision order or a mishandled comparator bit shows in `wr_data` at the very first write, since an ideal comparator on a fixed input voltage must reproduce that voltage exactly. Faults in the entry index, the write pointer or the interval counter show up within one sequence pass as a wrong `mux_sel`, `wr_addr` or flag timing. Errors in stop and halt handling show as one write too many or too few.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WARM = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;

  // Number of written results between flag events for an interval code.
  function automatic logic [4:0] intv_samples(input logic [3:0] code);
    logic [4:0] n;
    case (code)
      4'd0, 4'd1: n = 5'd1;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8: n = {1'b0, code};
      4'd9:       n = 5'd12;
      default:    n = 5'd16;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = (CNT_W'(1) << code) - CNT_W'(1);
  assign tick  = en && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + CNT_W'(1);
  end

  // R1
  div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0 && en) |=> !tick);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 12,
  parameter int ACQ   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             sampling,
  output logic [RES_W-1:0] trial,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int FRAME = ACQ + RES_W + 1;
  localparam int CYC_W = $clog2(FRAME);

  logic [CYC_W-1:0] cyc;
  logic [RES_W-1:0] sar;
  logic [RES_W-1:0] sel;

  // one select line per result bit, MSB decided first
  for (genvar i = 0; i < RES_W; i++) begin : g_sel
    assign sel[i] = (cyc == CYC_W'(ACQ + RES_W - 1 - i));
  end

  assign sampling = active && (cyc < CYC_W'(ACQ));
  assign trial    = sar | sel;
  assign done     = active && tick && (cyc == CYC_W'(FRAME - 1));
  assign result   = sar;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cyc <= '0;
      sar <= '0;
    end else if (tick) begin
      if (cyc == CYC_W'(FRAME - 1)) begin
        cyc <= '0;
        sar <= '0;
      end else begin
        cyc <= cyc + CYC_W'(1);
        sar <= (sar & ~sel) | (sel & {RES_W{cmp_in}});
      end
    end
  end

  // R3
  acq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && cyc == CYC_W'(ACQ - 1)) |=> !sampling);

  // R4
  done_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trial == result));

endmodule

// File: rtl/sar_result_buf.sv
module sar_result_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 12
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NUM_CFG    = 8,
  parameter int CH_W       = 3,
  parameter int BUF_DEPTH  = 8,
  parameter int RES_W      = 12,
  parameter int DIV_W      = 3,
  parameter int WARM_TICKS = 20,
  parameter int ACQ_TICKS  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         halt,
  input  logic                         conv_wr,
  input  logic                         conv_wdata,
  input  logic                         cont_mode,
  input  logic                         fast_start,
  input  logic [DIV_W-1:0]             div_code,
  input  logic [3:0]                   intv_code,
  input  logic [$clog2(NUM_CFG)-1:0]   seq_last,
  input  logic [NUM_CFG*CH_W-1:0]      chan_map,
  input  logic                         ie,
  input  logic                         flag_clr,
  input  logic                         cmp_in,
  output logic [CH_W-1:0]              mux_sel,
  output logic                         sampling,
  output logic [RES_W-1:0]             dac_code,
  output logic                         busy,
  output logic                         flag,
  output logic                         irq,
  output logic [$clog2(BUF_DEPTH)-1:0] last_addr,
  output logic                         wr_valid,
  output logic [$clog2(BUF_DEPTH)-1:0] wr_addr,
  output logic [RES_W-1:0]             wr_data,
  input  logic [$clog2(BUF_DEPTH)-1:0] rd_addr,
  output logic [RES_W-1:0]             rd_data
);
  localparam int SEQ_W  = $clog2(NUM_CFG);
  localparam int ADDR_W = $clog2(BUF_DEPTH);
  localparam int WARM_W = $clog2(WARM_TICKS);

  seq_state_t        state;
  logic [SEQ_W-1:0]  ent;
  logic [ADDR_W-1:0] ptr;
  logic [WARM_W-1:0] warm_cnt;
  logic [4:0]        scnt;
  logic              stop_req;

  logic              tick, conv_done, cnv_active, accept;
  logic              start_req, stop_wr, stop_now, seq_end, flag_hit;
  logic [4:0]        intv_n;
  logic [RES_W-1:0]  result;

  assign busy       = (state != ST_IDLE);
  assign cnv_active = (state == ST_CONV);
  assign start_req  = !busy && conv_wr && conv_wdata && !halt;
  assign stop_wr    = busy && conv_wr && !conv_wdata;
  assign stop_now   = stop_req || stop_wr;
  assign accept     = conv_done && !halt;
  assign intv_n     = intv_samples(intv_code);
  assign flag_hit   = accept && ((scnt + 5'd1) >= intv_n);
  assign seq_end    = (ent == seq_last);

  sar_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (busy),
    .code  (div_code),
    .tick  (tick)
  );

  sar_bit_engine #(.RES_W(RES_W), .ACQ(ACQ_TICKS)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (cnv_active),
    .tick     (tick),
    .cmp_in   (cmp_in),
    .sampling (sampling),
    .trial    (dac_code),
    .done     (conv_done),
    .result   (result)
  );

  sar_result_buf #(.DEPTH(BUF_DEPTH), .W(RES_W)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (ptr),
    .wdata (result),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign mux_sel  = chan_map[ent*CH_W +: CH_W];
  assign wr_valid = accept;
  assign wr_addr  = ptr;
  assign wr_data  = result;
  assign irq      = flag && ie;

  // sequencing: warm-up, entry walk, graceful stop, abort
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ent      <= '0;
      ptr      <= '0;
      warm_cnt <= '0;
      scnt     <= '0;
      stop_req <= 1'b0;
    end else if (halt) begin
      state    <= ST_IDLE;
      stop_req <= 1'b0;
    end else begin
      if (stop_wr) stop_req <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            state    <= fast_start ? ST_CONV : ST_WARM;
            ent      <= '0;
            ptr      <= '0;
            warm_cnt <= '0;
            scnt     <= '0;
            stop_req <= 1'b0;
          end
        end
        ST_WARM: begin
          if (tick) begin
            if (warm_cnt == WARM_W'(WARM_TICKS - 1)) state <= ST_CONV;
            else warm_cnt <= warm_cnt + WARM_W'(1);
          end
        end
        ST_CONV: begin
          if (accept) begin
            scnt <= flag_hit ? 5'd0 : scnt + 5'd1;
            if (stop_now || (!cont_mode && seq_end)) begin
              state    <= ST_IDLE;
              stop_req <= 1'b0;
            end else begin
              ent <= seq_end ? '0 : ent + SEQ_W'(1);
              ptr <= ptr + ADDR_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // data-available flag and latched address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      last_addr <= '0;
    end else if (start_req) begin
      flag <= 1'b0;
    end else if (flag_hit) begin
      flag      <= 1'b1;
      last_addr <= ptr;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  // R7
  halt_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !busy);

  // R8
  start_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_wr && conv_wdata && !busy && !halt) |=> !flag);

  // R10
  last_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (last_addr == $past(wr_addr)));

  // R6
  stop_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(halt)) |-> $past(wr_valid));

  // R5
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cont_mode && seq_end) |=> !busy);

endmodule

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0, conv_wr = 1'b0, conv_wdata = 1'b0;
  logic        cont_mode = 1'b0, fast_start = 1'b1, ie = 1'b1, flag_clr = 1'b0;
  logic [2:0]  div_code = 3'd0, seq_last = 3'd0, rd_addr = 3'd0;
  logic [3:0]  intv_code = 4'd1;
  logic [23:0] chan_map;
  logic        cmp_in;
  logic [2:0]  mux_sel, last_addr, wr_addr;
  logic        sampling, busy, flag, irq, wr_valid;
  logic [11:0] dac_code, wr_data, rd_data;
  logic [11:0] vin [8];

  always #2.5 clk = ~clk;

  sar_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .conv_wr(conv_wr), .conv_wdata(conv_wdata),
    .cont_mode(cont_mode), .fast_start(fast_start), .div_code(div_code),
    .intv_code(intv_code), .seq_last(seq_last), .chan_map(chan_map), .ie(ie),
    .flag_clr(flag_clr), .cmp_in(cmp_in), .mux_sel(mux_sel), .sampling(sampling),
    .dac_code(dac_code), .busy(busy), .flag(flag), .irq(irq), .last_addr(last_addr),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ideal comparator on a held input voltage per channel
  assign cmp_in = (dac_code <= vin[mux_sel]);

  int total = 0, bad = 0, wcount = 0, cycles = 0;
  string ctx = "reset";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic int samples(input int code);
    if (code <= 1) return 1;
    if (code <= 8) return code;
    if (code == 9) return 12;
    return 16;
  endfunction

  function automatic int chan(input int e);
    return int'(chan_map[e*3 +: 3]);
  endfunction

  // behavioural reference model
  int m_st = 0, m_div = 0, m_warm = 0, m_cyc = 0, m_ent = 0, m_ptr = 0;
  int m_scnt = 0, m_last = 0;
  bit m_stop = 0, m_flag = 0;
  int exp_buf [8];
  bit written [8];

  function automatic bit m_tick();
    return (m_st != 0) && (m_div >= (1 << div_code) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_div = 0; m_warm = 0; m_cyc = 0; m_ent = 0; m_ptr = 0;
      m_scnt = 0; m_last = 0; m_stop = 0; m_flag = 0;
    end else begin
      bit tk, dn, hit, strt;
      tk   = m_tick();
      dn   = (m_st == 2) && tk && (m_cyc == 15) && !halt;
      hit  = dn && (m_scnt + 1 >= samples(int'(intv_code)));
      strt = (m_st == 0) && conv_wr && conv_wdata && !halt;
      if (strt) m_flag = 0;
      else if (hit) begin m_flag = 1; m_last = m_ptr; end
      else if (flag_clr) m_flag = 0;
      if (dn) begin exp_buf[m_ptr] = int'(vin[chan(m_ent)]); written[m_ptr] = 1; end
      if (halt) begin
        m_st = 0; m_stop = 0; m_div = 0; m_cyc = 0;
      end else if (m_st == 0) begin
        if (strt) begin
          m_st = fast_start ? 2 : 1; m_div = 0; m_warm = 0; m_cyc = 0;
          m_ent = 0; m_ptr = 0; m_scnt = 0; m_stop = 0;
        end
      end else begin
        if (conv_wr && !conv_wdata) m_stop = 1;
        m_div = tk ? 0 : m_div + 1;
        if (tk && m_st == 1) begin
          if (m_warm == 19) m_st = 2; else m_warm++;
        end else if (tk && m_st == 2) begin
          if (m_cyc == 15) begin
            m_cyc = 0;
            m_scnt = hit ? 0 : m_scnt + 1;
            if (m_stop || (!cont_mode && m_ent == int'(seq_last))) begin
              m_st = 0; m_stop = 0; m_div = 0;
            end else begin
              m_ent = (m_ent == int'(seq_last)) ? 0 : m_ent + 1;
              m_ptr = (m_ptr + 1) % 8;
            end
          end else m_cyc++;
        end
      end
    end
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_wv;
      e_wv = (m_st == 2) && m_tick() && (m_cyc == 15) && !halt;
      chk(busy == (m_st != 0), "R5 busy", busy, m_st != 0);
      chk(wr_valid == e_wv, "R3 wr_valid", wr_valid, e_wv);
      chk(sampling == ((m_st == 2) && (m_cyc < 3)), "R3 sampling", sampling, (m_st == 2) && (m_cyc < 3));
      chk(int'(mux_sel) == chan(m_ent), "R3 mux_sel", mux_sel, chan(m_ent));
      chk(flag == m_flag, "R9 flag", flag, m_flag);
      chk(irq == (m_flag && ie), "R9 irq", irq, m_flag && ie);
      chk(int'(last_addr) == m_last, "R10 last_addr", last_addr, m_last);
      if (e_wv && wr_valid) begin
        chk(int'(wr_addr) == m_ptr, "R4 wr_addr", wr_addr, m_ptr);
        chk(int'(wr_data) == int'(vin[chan(m_ent)]), "R4 wr_data", wr_data, vin[chan(m_ent)]);
      end
      if (wr_valid) wcount++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic conv_pulse(input logic v);
    @(negedge clk); #1 conv_wr = 1'b1; conv_wdata = v;
    @(negedge clk); #1 conv_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    #1;
  endtask

  task automatic measure(input int expected, input string req);
    int n;
    n = 0;
    @(negedge clk); #1 conv_wr = 1'b1; conv_wdata = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (wr_valid) break;
      if (n == 1) #1 conv_wr = 1'b0;
    end
    #1 conv_wr = 1'b0;
    chk(n == expected, req, n, expected);
    wait_idle();
  endtask

  initial begin
    int w0;
    for (int c = 0; c < 8; c++) vin[c] = 12'(12'h0A5 + c * 12'h1F3);
    for (int e = 0; e < 8; e++) chan_map[e*3 +: 3] = 3'(7 - e);
    repeat (4) @(negedge clk);
    chk(busy == 0 && flag == 0 && irq == 0 && wr_valid == 0, "R5 reset idle", busy, 0);
    chk(last_addr == 0, "R10 reset last_addr", last_addr, 0);
    #1 rst_n = 1'b1;

    ctx = "R1 R2 latency";
    fast_start = 1; div_code = 0; measure(16, "R2 no warm-up div0");
    fast_start = 0; div_code = 0; measure(36, "R2 warm-up div0");
    fast_start = 1; div_code = 2; measure(64, "R1 divide by 4");
    fast_start = 0; div_code = 1; measure(72, "R1 R2 warm-up div2");

    ctx = "R5 single sequence";
    fast_start = 1; div_code = 0; seq_last = 3; intv_code = 2;
    vin[3] = 12'hFFF; vin[4] = 12'h000;
    #1 w0 = wcount;
    conv_pulse(1'b1);
    wait_idle();
    chk(wcount - w0 == 4, "R5 single writes", wcount - w0, 4);
    chk(flag == 1, "R9 flag after 4 samples, code 2", flag, 1);
    conv_pulse(1'b1);
    chk(flag == 0, "R8 start clears flag", flag, 0);
    conv_pulse(1'b1);
    chk(busy == 1, "R5 start while busy ignored", busy, 1);
    wait_idle();
    @(negedge clk); #1 flag_clr = 1'b1;
    @(negedge clk); #1 flag_clr = 1'b0;
    chk(flag == 0, "R8 flag_clr", flag, 0);

    ctx = "R4 R6 continuous stop";
    cont_mode = 1; seq_last = 2; intv_code = 9; vin[5] = 12'h800; vin[6] = 12'h7FF;
    conv_pulse(1'b1);
    repeat (16 * 13 + 5) @(negedge clk);
    #1 w0 = wcount;
    conv_pulse(1'b0);
    wait_idle();
    chk(wcount - w0 == 1, "R6 one write after stop", wcount - w0, 1);

    ctx = "R9 interval 16";
    seq_last = 0; intv_code = 10; ie = 0;
    conv_pulse(1'b1);
    repeat (16 * 33 + 3) @(negedge clk);
    conv_pulse(1'b0);
    wait_idle();

    ctx = "R9 interval code 0";
    intv_code = 0; ie = 1;
    conv_pulse(1'b1);
    repeat (16 * 3 + 2) @(negedge clk);
    conv_pulse(1'b0);
    wait_idle();

    ctx = "R9 interval 3";
    seq_last = 4; intv_code = 3; div_code = 1;
    conv_pulse(1'b1);
    repeat (32 * 10 + 9) @(negedge clk);
    conv_pulse(1'b0);
    wait_idle();

    ctx = "R7 halt";
    div_code = 0; seq_last = 1;
    conv_pulse(1'b1);
    repeat (16 * 2 + 8) @(negedge clk);
    #1 halt = 1'b1;
    w0 = wcount;
    @(negedge clk);
    chk(busy == 0, "R7 halt drops busy", busy, 0);
    #1 halt = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    chk(wcount == w0, "R7 no write after halt", wcount - w0, 0);

    ctx = "R7 R9 halt at write";
    seq_last = 0; intv_code = 1;
    conv_pulse(1'b1);
    repeat (14) @(negedge clk);
    #1 halt = 1'b1;
    @(negedge clk);
    chk(wr_valid == 0 && busy == 0, "R7 halt on final tick", wr_valid, 0);
    #1 halt = 1'b0;
    repeat (4) @(negedge clk);

    ctx = "R11 readback";
    for (int a = 0; a < 8; a++) begin
      if (written[a]) begin
        #1 rd_addr = 3'(a);
        #1 chk(int'(rd_data) == exp_buf[a], "R11 buffer read", rd_data, exp_buf[a]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule